// File: doc/BRIEF.md
# Bit-Serial Lookup FIR Filter

This block is a four-tap FIR filter for unsigned 8-bit samples that uses no multipliers. The four most recent samples sit in a short delay line. A conversion reads one bit position from all four taps in each cycle, starting at the least significant bit. Those four bits form an address into a 16-entry lookup table. Each entry holds the sum of the coefficients whose address bit is set. The table word is added into a running accumulator that shifts right by one place per bit. After eight bit-cycles the full-precision output is ready.

A producer presents a sample with a one-cycle valid strobe while the filter is idle. The filter then works for eight cycles and raises a one-cycle result flag, after which it is idle again. A sample offered while a conversion is in progress, or during the result cycle, is dropped. A new sample can therefore be accepted every tenth cycle. The coefficients are elaboration-time parameters, and the lookup table is derived from them.

Top module: `dafir_filter`

## Requirements
- R1: After reset, resultValid is 0, result is 0 and all four delay-line taps hold zero. The first output after reset therefore depends only on the first sample.
- R2: Each output equals c0*x[n] + c1*x[n-1] + c2*x[n-2] + c3*x[n-3]. Here x[n] is the sample just accepted, all values are unsigned, and the result is exact in 18 bits. The default coefficients are c0=3, c1=100, c2=255 and c3=17, packed with c0 in COEFS bits 7:0 and c3 in bits 31:24.
- R3: A sample accepted in cycle c (sampleValid high while idle) makes resultValid high in cycle c+9 for exactly one cycle. There is no other resultValid pulse.
- R4: sampleValid is ignored in cycles c+1 through c+9, including the result cycle. A sample offered in cycle c+10 is accepted.
- R5: Tap i holds the sample accepted i conversions earlier. The sample from four conversions ago is discarded and no longer affects the output.
- R6: With 255 on all four taps, the output is exactly 255*(c0+c1+c2+c3), with no loss of carry.
- R7: Lookup entry k is the sum of the coefficients c_i for every tap i whose bit is set in k, where address bit i comes from tap i. Entry 0 is zero.
- R8: Sample bits are consumed least significant first, one bit position per cycle for eight cycles. A sample with only bit 7 set is weighted by 128.
- R9: result keeps the last output value while the filter stays idle after a result cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleIn | input | 8 | Unsigned input sample |
| sampleValid | input | 1 | Sample strobe, taken only while idle |
| result | output | 18 | Filter output, meaningful when resultValid is high |
| resultValid | output | 1 | One-cycle flag marking a finished output |

## Verification
Two events can meet in the same cycle: a sample arriving and the result flag of the previous conversion. The bench provokes this by driving sampleValid high with a stray value in every busy cycle, including the result cycle, and then presenting the next real sample exactly one cycle later. The stray value must leave the delay line untouched, and the real sample must still be taken. Both are judged at the ports: the next outputs must match a reference delay line that never saw the stray values, and every result flag must land exactly nine cycles after its own sample.

// File: rtl/dafir_pkg.sv
package dafir_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } dafirState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadTaps;    // shift a new sample into the delay line
    logic clearAcc;    // first bit-cycle: start from an empty accumulator
    logic accumulate;  // a bit-cycle is running
  } dafirCtrl_t;

endpackage

// File: rtl/dafir_ctrl.sv
module dafir_ctrl
  import dafir_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  localparam int IDX_W = $clog2(SAMPLE_W),
  localparam int LAST_BIT = SAMPLE_W - 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleValid,
  output dafirCtrl_t       strobes,
  output logic [IDX_W-1:0] bitIdx,
  output logic             resultValid
);

  dafirState_t state;
  logic [IDX_W-1:0] bitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (sampleValid) begin
            state  <= ST_RUN;
            bitCnt <= '0;
          end
        end
        ST_RUN: begin
          bitCnt <= bitCnt + 1'b1;
          if (bitCnt == IDX_W'(LAST_BIT)) begin
            state <= ST_DONE;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.loadTaps   = (state == ST_IDLE) && sampleValid;
    strobes.accumulate = (state == ST_RUN);
    strobes.clearAcc   = (state == ST_RUN) && (bitCnt == '0);
  end

  assign bitIdx      = bitCnt;
  assign resultValid = (state == ST_DONE);

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  // R3
  done_after_last_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> ($past(strobes.accumulate) && ($past(bitIdx) == IDX_W'(LAST_BIT))));

endmodule

// File: rtl/dafir_rom.sv
module dafir_rom #(
  parameter int TAPS = 4,
  parameter int COEF_W = 8,
  parameter logic [TAPS*COEF_W-1:0] COEFS = '0,
  localparam int ROM_W = COEF_W + $clog2(TAPS),
  localparam int DEPTH = 1 << TAPS
) (
  input  logic [TAPS-1:0]  romAddr,
  output logic [ROM_W-1:0] romWord
);

  function automatic logic [ROM_W-1:0] entryFor(input int k);
    logic [ROM_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < TAPS; i++) begin
      if (((k >> i) & 1) == 1) begin
        acc = acc + ROM_W'(COEFS[i*COEF_W +: COEF_W]);
      end
    end
    return acc;
  endfunction

  logic [ROM_W-1:0] table_q [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_entry
    assign table_q[k] = entryFor(k);
  end

  assign romWord = table_q[romAddr];

  // R7
  always_comb begin
    rom_zero_chk: assert (romAddr != '0 || romWord == '0);
  end

endmodule

// File: rtl/dafir_datapath.sv
module dafir_datapath
  import dafir_pkg::*;
#(
  parameter int TAPS = 4,
  parameter int SAMPLE_W = 8,
  parameter int COEF_W = 8,
  parameter logic [TAPS*COEF_W-1:0] COEFS = '0,
  localparam int IDX_W = $clog2(SAMPLE_W),
  localparam int ROM_W = COEF_W + $clog2(TAPS),
  localparam int ACC_W = ROM_W + 1,
  localparam int LOW_W = SAMPLE_W - 1,
  localparam int OUT_W = ACC_W + LOW_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  dafirCtrl_t          strobes,
  input  logic [IDX_W-1:0]    bitIdx,
  output logic [OUT_W-1:0]    result
);

  logic [SAMPLE_W-1:0] taps [TAPS];
  logic [TAPS-1:0]     romAddr;
  logic [ROM_W-1:0]    romWord;
  logic [ACC_W-1:0]    acc;
  logic [ACC_W-1:0]    accBase;
  logic [ACC_W-1:0]    accNext;
  logic [LOW_W-1:0]    lowBits;

  // delay line: tap 0 newest
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < TAPS; i++) taps[i] <= '0;
    end else if (strobes.loadTaps) begin
      taps[0] <= sampleIn;
      for (int i = 1; i < TAPS; i++) taps[i] <= taps[i-1];
    end
  end

  // one bit from each tap forms the lookup address
  for (genvar i = 0; i < TAPS; i++) begin : g_addr
    assign romAddr[i] = taps[i][bitIdx];
  end

  dafir_rom #(
    .TAPS  (TAPS),
    .COEF_W(COEF_W),
    .COEFS (COEFS)
  ) u_rom (
    .romAddr(romAddr),
    .romWord(romWord)
  );

  always_comb begin
    accBase = strobes.clearAcc ? '0 : acc;
    accNext = (accBase >> 1) + ACC_W'(romWord);
  end

  // upper part in acc, retired low-order bits in lowBits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc     <= '0;
      lowBits <= '0;
    end else if (strobes.accumulate) begin
      acc     <= accNext;
      lowBits <= {acc[0], lowBits[LOW_W-1:1]};
    end
  end

  assign result = {acc, lowBits};

  // R4
  no_load_while_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.accumulate |-> !strobes.loadTaps);

  // R3
  start_follows_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadTaps |=> strobes.clearAcc);

  // R8
  lsb_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearAcc |-> (bitIdx == '0));

endmodule

// File: rtl/dafir_filter.sv
module dafir_filter
  import dafir_pkg::*;
#(
  parameter int TAPS = 4,
  parameter int SAMPLE_W = 8,
  parameter int COEF_W = 8,
  parameter logic [TAPS*COEF_W-1:0] COEFS = {8'd17, 8'd255, 8'd100, 8'd3},
  localparam int IDX_W = $clog2(SAMPLE_W),
  localparam int OUT_W = COEF_W + $clog2(TAPS) + SAMPLE_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic                sampleValid,
  output logic [OUT_W-1:0]    result,
  output logic                resultValid
);

  dafirCtrl_t       strobes;
  logic [IDX_W-1:0] bitIdx;

  dafir_ctrl #(
    .SAMPLE_W(SAMPLE_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sampleValid(sampleValid),
    .strobes    (strobes),
    .bitIdx     (bitIdx),
    .resultValid(resultValid)
  );

  dafir_datapath #(
    .TAPS    (TAPS),
    .SAMPLE_W(SAMPLE_W),
    .COEF_W  (COEF_W),
    .COEFS   (COEFS)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .sampleIn(sampleIn),
    .strobes (strobes),
    .bitIdx  (bitIdx),
    .result  (result)
  );

endmodule

// File: tb/tb_dafir_filter.sv
module tb_dafir_filter;

  localparam logic [31:0] COEFS = {8'd17, 8'd255, 8'd100, 8'd3};
  localparam int COEF_C0 = 3;
  localparam int COEF_C1 = 100;
  localparam int COEF_C2 = 255;
  localparam int COEF_C3 = 17;

  logic        clk = 1'b0;
  logic        rstN;
  logic [7:0]  sampleIn;
  logic        sampleValid;
  logic [17:0] result;
  logic        resultValid;

  always #2 clk = ~clk;

  dafir_filter #(.COEFS(COEFS)) dut (
    .clk        (clk),
    .rstN       (rstN),
    .sampleIn   (sampleIn),
    .sampleValid(sampleValid),
    .result     (result),
    .resultValid(resultValid)
  );

  int cycleCnt = 0;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  bit haveResult = 1'b0;
  int lastResult = 0;
  int model [4];
  int expVal [$];
  int expCyc [$];
  string expTag [$];

  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // driver: offer one sample while idle, then fill the busy window
  task automatic accept(input int x, input string tag, input bit junk);
    int e;
    @(negedge clk);
    sampleIn = 8'(x);
    sampleValid = 1'b1;
    model[3] = model[2];
    model[2] = model[1];
    model[1] = model[0];
    model[0] = x;
    e = COEF_C0*model[0] + COEF_C1*model[1] + COEF_C2*model[2] + COEF_C3*model[3];
    expVal.push_back(e);
    expCyc.push_back(cycleCnt + 9);
    expTag.push_back(tag);
    for (int k = 1; k <= 9; k++) begin
      @(negedge clk);
      sampleValid = junk;
      sampleIn = junk ? 8'((x ^ (k * 37 + 1)) & 255) : 8'd0;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      sampleValid = 1'b0;
    end
    if (haveResult) begin
      // R9 result stays put while idle
      check(result == 18'(lastResult), "R9", "held result", int'(result), lastResult);
    end
  endtask

  // monitor: pop expected items as results appear
  always @(negedge clk) begin
    if (rstN && !finished) begin
      while (expCyc.size() > 0 && cycleCnt > expCyc[0]) begin
        check(1'b0, "R3", "missing result pulse", cycleCnt, expCyc[0]);
        void'(expVal.pop_front());
        void'(expCyc.pop_front());
        void'(expTag.pop_front());
      end
      if (resultValid) begin
        if (expCyc.size() == 0) begin
          check(1'b0, "R3", "unexpected result pulse", cycleCnt, -1);
        end else begin
          check(result == 18'(expVal[0]), expTag[0], "result value",
                int'(result), expVal[0]);
          check(cycleCnt == expCyc[0], "R3", "result cycle", cycleCnt, expCyc[0]);
          void'(expVal.pop_front());
          void'(expCyc.pop_front());
          void'(expTag.pop_front());
        end
        lastResult = int'(result);
        haveResult = 1'b1;
      end
    end
  end

  initial begin
    #80000;
    if (!finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL R3 watchdog expired: actual %0d expected 0", cycleCnt);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) model[i] = 0;
    rstN = 1'b0;
    sampleValid = 1'b0;
    sampleIn = 8'd0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(resultValid == 1'b0, "R1", "resultValid in reset", int'(resultValid), 0);
    check(result == 18'd0, "R1", "result in reset", int'(result), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(resultValid == 1'b0, "R1", "resultValid after reset", int'(resultValid), 0);

    // R1 first output sees cleared taps only
    accept(10, "R1", 1'b0);
    idle(3);

    // R7 impulse walks through each coefficient; R5 oldest drops out
    accept(0, "R5", 1'b0);
    accept(0, "R5", 1'b0);
    accept(0, "R5", 1'b0);
    accept(0, "R5", 1'b0);
    accept(1, "R7", 1'b0);
    accept(0, "R7", 1'b0);
    accept(0, "R7", 1'b0);
    accept(0, "R7", 1'b0);
    accept(0, "R5", 1'b0);
    accept(5, "R7", 1'b0);
    accept(5, "R7", 1'b0);
    idle(4);

    // R6 all-ones on every tap
    accept(255, "R6", 1'b0);
    accept(255, "R6", 1'b0);
    accept(255, "R6", 1'b0);
    accept(255, "R6", 1'b0);

    // R8 only the top bit set
    accept(128, "R8", 1'b0);
    accept(0, "R8", 1'b0);
    idle(2);

    // R4 stray strobes in every busy cycle and in the result cycle
    accept(77, "R4", 1'b1);
    accept(200, "R4", 1'b1);
    accept(13, "R4", 1'b1);
    accept(254, "R4", 1'b1);
    idle(5);

    // R2 mixed values
    accept(99, "R2", 1'b0);
    accept(1, "R2", 1'b0);
    accept(170, "R2", 1'b0);
    accept(85, "R2", 1'b0);
    accept(240, "R2", 1'b0);
    idle(12);

    check(expCyc.size() == 0, "R3", "outstanding results", expCyc.size(), 0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule